// File: doc/BRIEF.md
# Strobe Delay Tap Calibration Sweep

This block tunes the delay tap shared by the read data-strobe lanes of a memory interface. When software pulses the start input, the block steps through every tap setting from zero to the highest one. At each setting it loads the tap into all strobe lanes at once, starts an external memory self-test engine, and waits for that engine to report completion. It then drops the start request and judges the compare count the engine returned. The block keeps the lowest passing tap and the most recent passing tap, and it counts the passing taps.

When the sweep ends, the block loads one final tap into every lane. If at least one tap passed, the final tap is the floored midpoint of the first and last passing taps. If no tap passed, the block restores the tap value it sampled when the sweep started. The self-test engine and the delay line are outside this block. If the engine never reports completion, a cycle limit makes sure the sweep still moves on.

All pins are plain control and status signals. No data stream crosses the block boundary, so there is no valid/ready handshake and no back-pressure. The engine handshake is a level request held until completion, and the tap load is a one-cycle strobe.

Top module: `strobe_tap_cal`

## Requirements
- R1: After an accepted start, the block issues exactly one tap load per setting, in ascending order from 0 to 2^TAP_W-1 (0 to 63 by default). Every bit of `tap_load_o` is high on each load, so all lanes get the same value shown on `tap_o`.
- R2: `bist_start_o` rises in the cycle after a sweep tap load. It stays high until completion or timeout. It is low for at least one cycle before the next load, and it is never high while the block is idle.
- R3: The engine status word carries the done flag in bit 0 and an 8-bit compare count in bits 8:1. A tap passes only when the done flag is seen and the count equals exactly 8. Counts of 7, 9 or any other value fail.
- R4: Let L be `bist_limit_i` as sampled at start, with 0 treated as 1. A done flag seen within L cycles of the request rising is accepted, including in the L-th cycle, where done takes priority over expiry. If no done is seen by then, the tap fails.
- R5: The first passing tap is captured once per sweep. The last passing tap is updated on every pass, even when the passes are not contiguous.
- R6: If any tap passed, the final tap is floor((first + last) / 2), taken modulo 2^TAP_W.
- R7: If no tap passed, the final tap equals `tap_init_i` as sampled in the cycle the start was accepted.
- R8: The final tap is loaded into all lanes in the same cycle that `cal_done_o` pulses. `pass_cnt_o` then holds the number of passing taps until the next start. At reset all outputs are low.
- R9: `cal_busy_o` is high from the cycle after an accepted start through the `cal_done_o` cycle. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cal_start_i | input | 1 | Start a calibration sweep (only accepted when idle) |
| tap_init_i | input | TAP_W | Tap value to restore if no tap passes |
| bist_limit_i | input | TMO_W | Maximum number of cycles to wait for the engine at each tap |
| cal_busy_o | output | 1 | A sweep is in progress |
| cal_done_o | output | 1 | One-cycle pulse when the final tap is loaded |
| tap_o | output | TAP_W | Tap value presented to the lanes |
| tap_load_o | output | LANES | Per-lane load strobe for `tap_o` |
| bist_start_o | output | 1 | Level request to the self-test engine |
| bist_status_i | input | CNT_W+1 | Engine status: bit 0 is done, bits CNT_W:1 are the compare count |
| pass_cnt_o | output | TAP_W+1 | Number of passing taps in the last sweep |

## Verification
Two functions can land in the same cycle: the engine's done flag and the expiry of the wait limit. The bench makes them collide by setting a tap's response latency equal to the programmed limit. It judges the result by whether that tap appears inside the final window and in the pass count, next to a tap whose latency is one cycle over the limit. A second overlap comes from a start pulse issued in the middle of a sweep. The bench judges that case by checking that the load sequence stays strictly ascending and that only one done pulse follows.

// File: rtl/stc_pkg.sv
package stc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_APPLY = 3'd1,
    ST_RUN   = 3'd2,
    ST_STOP  = 3'd3,
    ST_FINAL = 3'd4
  } stc_state_e;
endpackage

// File: rtl/stc_bist_seq.sv
// Waits on the self-test engine for one tap and judges its reply.
module stc_bist_seq #(
  parameter int CNT_W    = 8,
  parameter int GOLD_CNT = 8,
  parameter int TMO_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [CNT_W:0]   status_i,
  input  logic [TMO_W-1:0] lim_i,
  output logic             fin_o,
  output logic             pass_o
);
  logic [TMO_W-1:0] wait_q;
  logic [TMO_W-1:0] lim_m1;
  logic             done_seen;
  logic             expired;

  assign done_seen = status_i[0];
  assign lim_m1    = (lim_i == '0) ? '0 : lim_i - 1'b1;
  assign expired   = (wait_q >= lim_m1);
  assign fin_o     = run_i && (done_seen || expired);
  assign pass_o    = run_i && done_seen &&
                     (status_i[CNT_W:1] == CNT_W'(GOLD_CNT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                wait_q <= '0;
    else if (run_i && !fin_o)  wait_q <= wait_q + 1'b1;
    else                       wait_q <= '0;
  end

  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (wait_q <= lim_m1)); // R4
endmodule

// File: rtl/stc_window.sv
// Tracks the passing window and computes the final tap.
module stc_window #(
  parameter int TAP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             upd_i,
  input  logic             pass_i,
  input  logic [TAP_W-1:0] tap_i,
  input  logic [TAP_W-1:0] fallback_i,
  output logic [TAP_W-1:0] result_o,
  output logic [TAP_W:0]   pass_cnt_o
);
  logic             have_first_q;
  logic [TAP_W-1:0] first_q;
  logic [TAP_W-1:0] last_q;
  logic [TAP_W:0]   cnt_q;
  logic [TAP_W:0]   sum;
  logic [TAP_W-1:0] mid;

  assign sum        = {1'b0, first_q} + {1'b0, last_q};
  assign mid        = sum[TAP_W:1];
  assign result_o   = (cnt_q != '0) ? mid : fallback_i;
  assign pass_cnt_o = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_first_q <= 1'b0;
      first_q      <= '0;
      last_q       <= '0;
      cnt_q        <= '0;
    end else if (clr_i) begin
      have_first_q <= 1'b0;
      first_q      <= '0;
      last_q       <= '0;
      cnt_q        <= '0;
    end else if (upd_i && pass_i) begin
      cnt_q  <= cnt_q + 1'b1;
      last_q <= tap_i;
      if (!have_first_q) begin
        first_q      <= tap_i;
        have_first_q <= 1'b1;
      end
    end
  end

  AST_FIRST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (have_first_q && !clr_i) |=> $stable(first_q)); // R5
  AST_LAST_GE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    have_first_q |-> (last_q >= first_q)); // R5
  AST_MID_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    have_first_q |-> ((mid >= first_q) && (mid <= last_q))); // R6
endmodule

// File: rtl/strobe_tap_cal.sv
module strobe_tap_cal
  import stc_pkg::*;
#(
  parameter int TAP_W    = 6,
  parameter int LANES    = 2,
  parameter int CNT_W    = 8,
  parameter int GOLD_CNT = 8,
  parameter int TMO_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cal_start_i,
  input  logic [TAP_W-1:0] tap_init_i,
  input  logic [TMO_W-1:0] bist_limit_i,
  output logic             cal_busy_o,
  output logic             cal_done_o,
  output logic [TAP_W-1:0] tap_o,
  output logic [LANES-1:0] tap_load_o,
  output logic             bist_start_o,
  input  logic [CNT_W:0]   bist_status_i,
  output logic [TAP_W:0]   pass_cnt_o
);
  localparam logic [TAP_W-1:0] TAP_LAST = '1;

  stc_state_e       state_q;
  logic [TAP_W-1:0] tap_q;
  logic [TAP_W-1:0] init_q;
  logic [TMO_W-1:0] lim_q;
  logic             res_pass_q;
  logic             accept;
  logic             run;
  logic             fin;
  logic             pass;
  logic             load;
  logic [TAP_W-1:0] result;

  assign accept = (state_q == ST_IDLE) && cal_start_i;
  assign run    = (state_q == ST_RUN);
  assign load   = (state_q == ST_APPLY) || (state_q == ST_FINAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      tap_q      <= '0;
      init_q     <= '0;
      lim_q      <= '0;
      res_pass_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (cal_start_i) begin
          init_q  <= tap_init_i;
          lim_q   <= bist_limit_i;
          tap_q   <= '0;
          state_q <= ST_APPLY;
        end
        ST_APPLY: state_q <= ST_RUN;
        ST_RUN: if (fin) begin
          res_pass_q <= pass;
          state_q    <= ST_STOP;
        end
        ST_STOP: begin
          if (tap_q == TAP_LAST) begin
            state_q <= ST_FINAL;
          end else begin
            tap_q   <= tap_q + 1'b1;
            state_q <= ST_APPLY;
          end
        end
        ST_FINAL: begin
          tap_q   <= result;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  stc_bist_seq #(.CNT_W(CNT_W), .GOLD_CNT(GOLD_CNT), .TMO_W(TMO_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (run),
    .status_i (bist_status_i),
    .lim_i    (lim_q),
    .fin_o    (fin),
    .pass_o   (pass)
  );

  stc_window #(.TAP_W(TAP_W)) u_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (accept),
    .upd_i      (state_q == ST_STOP),
    .pass_i     (res_pass_q),
    .tap_i      (tap_q),
    .fallback_i (init_q),
    .result_o   (result),
    .pass_cnt_o (pass_cnt_o)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign tap_load_o[g] = load;
  end

  assign tap_o        = (state_q == ST_FINAL) ? result : tap_q;
  assign bist_start_o = run;
  assign cal_busy_o   = (state_q != ST_IDLE);
  assign cal_done_o   = (state_q == ST_FINAL);

  AST_LOAD_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bist_start_o) |-> $past(tap_load_o[0])); // R2
  AST_START_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (bist_start_o && bist_status_i[0]) |=> !bist_start_o); // R2
  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_busy_o) |-> $past(cal_start_i)); // R9
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done_o |=> !cal_busy_o); // R9
endmodule

// File: tb/strobe_tap_cal_tb_top.sv
module strobe_tap_cal_tb_top;
  localparam int TAP_W = 6;
  localparam int LANES = 2;
  localparam int CNT_W = 8;
  localparam int TMO_W = 16;
  localparam int NTAP  = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cal_start_i = 1'b0;
  logic [TAP_W-1:0] tap_init_i = '0;
  logic [TMO_W-1:0] bist_limit_i = 16'd4;
  logic cal_busy_o, cal_done_o, bist_start_o;
  logic [TAP_W-1:0] tap_o;
  logic [LANES-1:0] tap_load_o;
  logic [CNT_W:0] bist_status_i = '0;
  logic [TAP_W:0] pass_cnt_o;

  always #5 clk = ~clk;

  strobe_tap_cal #(.TAP_W(TAP_W), .LANES(LANES), .CNT_W(CNT_W), .TMO_W(TMO_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cal_start_i(cal_start_i), .tap_init_i(tap_init_i),
    .bist_limit_i(bist_limit_i), .cal_busy_o(cal_busy_o), .cal_done_o(cal_done_o),
    .tap_o(tap_o), .tap_load_o(tap_load_o), .bist_start_o(bist_start_o),
    .bist_status_i(bist_status_i), .pass_cnt_o(pass_cnt_o)
  );

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  int done_seen = 0;
  int lat_a [NTAP];
  int cnt_a [NTAP];
  int rcnt = 0;
  int exp_cnt = 0;
  int exp_loads[$];
  bit mb = 0;
  bit armed = 0;
  bit prev_start = 0;
  bit prev_load = 0;
  string tag = "R1";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Reference model, engine responder and per-clock comparison.
  always @(negedge clk) begin
    cycles++;
    if (rst_n && armed) begin
      chk(cal_busy_o == mb, "R9 busy", cal_busy_o, mb);
      chk(!(bist_start_o && !mb), "R2 start while idle", bist_start_o, 0);
      chk(!(bist_start_o && tap_load_o != 0), "R2 start overlaps load", bist_start_o, 0);
      if (bist_start_o && !prev_start)
        chk(prev_load, "R2 start follows load", prev_load, 1);
      if (tap_load_o != 0) begin
        int e;
        e = (exp_loads.size() > 0) ? exp_loads.pop_front() : -1;
        chk(tap_load_o == '1, "R1 all lanes strobed", tap_load_o, 3);
        chk(!prev_start, "R2 gap before load", prev_start, 0);
        chk(int'(tap_o) == e, cal_done_o ? tag : "R1 sweep order", tap_o, e);
      end
      if (cal_done_o) begin
        chk(tap_load_o == '1, "R8 final load with done", tap_load_o, 3);
        chk(int'(pass_cnt_o) == exp_cnt, "R8 pass count", pass_cnt_o, exp_cnt);
        chk(exp_loads.size() == 0, "R1 load count", exp_loads.size(), 0);
        done_seen++;
      end
      if (cal_done_o) mb = 0;
      if (cal_start_i && !mb) mb = 1;
      prev_start = bist_start_o;
      prev_load  = (tap_load_o != 0);
    end
    if (bist_start_o) begin
      rcnt++;
      if (lat_a[tap_o] != 0 && rcnt == lat_a[tap_o])
        bist_status_i = {cnt_a[tap_o][CNT_W-1:0], 1'b1};
    end else begin
      rcnt = 0;
      bist_status_i = '0;
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic set_all(input int lat, input int cnt);
    for (int i = 0; i < NTAP; i++) begin lat_a[i] = lat; cnt_a[i] = cnt; end
  endtask

  task automatic run_cal(input int init, input int lim, input string req, input bit poke);
    int first, last, n, leff, d0;
    first = -1; last = 0; n = 0;
    leff = (lim == 0) ? 1 : lim;
    for (int t = 0; t < NTAP; t++) begin
      exp_loads.push_back(t);
      if (cnt_a[t] == 8 && lat_a[t] != 0 && lat_a[t] <= leff) begin
        if (first < 0) first = t;
        last = t;
        n++;
      end
    end
    exp_loads.push_back(n != 0 ? ((first + last) / 2) % NTAP : init);
    exp_cnt = n;
    tag = req;
    d0 = done_seen;
    @(posedge clk); #1;
    tap_init_i = TAP_W'(init);
    bist_limit_i = TMO_W'(lim);
    cal_start_i = 1'b1;
    @(posedge clk); #1;
    cal_start_i = 1'b0;
    tap_init_i = ~TAP_W'(init);
    if (poke) begin
      repeat (40) @(posedge clk);
      #1 cal_start_i = 1'b1;
      @(posedge clk); #1 cal_start_i = 1'b0;
    end
    for (int k = 0; k < 20000 && done_seen == d0; k++) @(posedge clk);
    chk(done_seen == d0 + 1, {req, " sweep completes"}, done_seen - d0, 1);
    repeat (3) @(posedge clk);
    chk(!cal_busy_o, "R9 idle after done", cal_busy_o, 0);
    chk(int'(pass_cnt_o) == exp_cnt, "R8 count held", pass_cnt_o, exp_cnt);
  endtask

  initial begin
    set_all(2, 7);
    repeat (3) @(posedge clk);
    #2;
    chk(!cal_busy_o && !cal_done_o && !bist_start_o && tap_load_o == 0 && pass_cnt_o == 0,
        "R8 reset state", {cal_busy_o, bist_start_o}, 0);
    #1 rst_n = 1'b1;
    armed = 1;
    // Contiguous window 20..30: midpoint 25.
    set_all(2, 3);
    for (int i = 20; i <= 30; i++) cnt_a[i] = 8;
    run_cal(5, 4, "R6 contiguous", 0);
    // Non-contiguous passes at 5 and 40: last follows every pass.
    set_all(3, 0);
    cnt_a[5] = 8; cnt_a[40] = 8;
    run_cal(9, 4, "R5 gap window", 0);
    // No pass: restore the initial tap.
    set_all(1, 9);
    run_cal(42, 4, "R7 restore", 0);
    // Counts one above and below the golden value fail; only tap 63 passes.
    set_all(1, 9);
    for (int i = 0; i < 32; i++) cnt_a[i] = 7;
    cnt_a[63] = 8;
    run_cal(1, 4, "R3 exact count", 0);
    // Done on the limit cycle passes, one cycle past fails, no done fails.
    set_all(0, 8);
    lat_a[10] = 3; lat_a[11] = 4; lat_a[12] = 1; lat_a[20] = 0;
    run_cal(7, 3, "R4 limit edge", 0);
    // Limit 0 acts as 1: only latency-1 taps pass.
    set_all(2, 8);
    lat_a[33] = 1; lat_a[35] = 1;
    run_cal(0, 0, "R4 zero limit", 0);
    // All taps pass: first 0, last 63, midpoint 31; a start mid-sweep is ignored.
    set_all(1, 8);
    run_cal(3, 4, "R9 full window", 1);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule